// File: doc/BRIEF.md
# Shared-Pin Four-Bit I/O Port Controller

This block controls four general-purpose pins that are shared with the low address outputs of an external bus. A simple address/data bus with separate write and read strobes reaches five 8-bit registers:

- a write-only direction register;
- an output data register;
- a read-only view of the pin levels;
- a pull-up enable register;
- an open-drain enable register.

Only bits 3..0 of each register are used. For every pin the block chooses one of three roles: an address output, a port data output or an input. It then produces the pad controls: output value, output enable and pull-up enable.

The operating mode sets whether address outputs can claim pins. Modes 4, 5 and 6 are the expanded modes, in which address enables take over pins. Every other mode value, including single-chip mode 7, leaves the pins to the direction register.

The block honours two resets and two standby states:

- **Power-on reset** is asynchronous and active low. It clears every register.
- **Manual reset** is synchronous and active low. It clears the working registers but keeps the direction register.
- **Hardware standby** clears everything, including the direction register, and floats all pins.
- **Software standby** freezes the registers. A hold control then chooses whether the address pins keep their last value or float.

Top module: `pin_mux_port`

## Requirements
- R1: After power-on reset the data, pull-up and open-drain registers hold 0, all output enables are 0 and all pull-ups are off.
- R2: A write to data (0xFF09), pull-up (0xFE40) or open-drain (0xFE47) takes effect at the clock edge after the write strobe. A read of these registers returns the stored value in bits 3..0 and all ones in bits 7..4, whatever was written to bits 7..4.
- R3: Reading the direction register (0xFE39) returns 0xFF whatever it holds. With the read strobe low, or at an unmapped address, the read data is 0x00.
- R4: A pin whose direction bit is 1 and which is not an address output drives its data bit with output enable 1. With direction bit 0 its output enable is 0.
- R5: In modes 4, 5 and 6, a pin whose address-enable bit is 1 drives the matching address bit with output enable 1, regardless of its direction bit.
- R6: In any mode other than 4, 5 and 6, address-enable bits have no effect and every pin follows its direction bit.
- R7: A manual reset clears data, pull-up and open-drain to 0 and leaves the direction register unchanged.
- R8: Hardware standby forces every output enable and pull-up to 0 at once and clears all registers, including the direction register, at the next edge.
- R9: During software standby all register contents are held and bus writes are ignored.
- R10: In software standby an address pin drives the address value from the last cycle before standby when the hold control is 1, and has output enable 0 when it is 0.
- R11: The pin-state register (0xFFB9) returns in bits 3..0 the pin inputs as they were two clock edges earlier, and all ones in bits 7..4.
- R12: The pull-up output of a pin equals its pull-up bit only while the pin is an input. It is 0 while the pin drives data or an address.
- R13: An output port pin with its open-drain bit set has output enable 1 only while its data bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| stby_hold | input | 1 | Address pins keep driving in software standby when 1 |
| mode | input | 3 | Operating mode; 4, 5, 6 are expanded |
| addr_en | input | 4 | Per-pin address output enables |
| addr_out | input | 4 | Address bits from the bus controller |
| bus_addr | input | 16 | Register address (low 16 bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 4 | Pin levels from the pads |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables |
| pin_pu | output | 4 | Pad pull-up enables |

## Verification
The bench targets the points where reset and standby treat the registers differently:

- A design that cleared the direction register on a manual reset would drop its outputs to input after the reset pulse.
- A design that ignored hardware standby would keep driving pins.
- A design that sampled the address in standby would show the new address instead of the one held from before entry.

The vector table sweeps the modes, including mode 3, so that address enables leaking outside modes 4 to 6 would show up as stray output enables. It also covers open-drain pins with both data values, where an inverted enable would appear directly on the output-enable pins. The pin-state read is checked after one edge and after two, so a synchronizer one stage short or one stage long is exposed.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
    localparam int PINS   = 4;
    localparam int BUS_DW = 8;
    localparam int BUS_AW = 16;

    typedef logic [PINS-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t dir;
        pinvec_t dat;
        pinvec_t pull;
        pinvec_t odrain;
    } port_regs_t;

    function automatic logic is_expanded(input logic [2:0] m);
        return (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
    endfunction
endpackage

// File: rtl/pmp_sync.sv
module pmp_sync #(
    parameter int N = pmp_pkg::PINS
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_sync
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pin_in;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign pin_sync = sy_q.s2;

    // edges since reset, saturating, so the check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)            age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R11
    two_stage_delay_chk: assert property (@(posedge clk) disable iff (!por_n)
        (age_q == 2'd2) |-> (pin_sync == $past(pin_in, 2)));
endmodule

// File: rtl/pmp_regs.sv
module pmp_regs #(
    parameter logic [15:0] ADDR_DIR  = 16'hFE39,
    parameter logic [15:0] ADDR_DAT  = 16'hFF09,
    parameter logic [15:0] ADDR_PIN  = 16'hFFB9,
    parameter logic [15:0] ADDR_PULL = 16'hFE40,
    parameter logic [15:0] ADDR_OD   = 16'hFE47
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        mrst_n,
    input  logic                        hw_stby,
    input  logic                        sw_stby,
    input  logic [pmp_pkg::BUS_AW-1:0]  bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [pmp_pkg::BUS_DW-1:0]  bus_wdata,
    input  pmp_pkg::pinvec_t            pin_sync,
    output logic [pmp_pkg::BUS_DW-1:0]  bus_rdata,
    output pmp_pkg::port_regs_t         regs
);
    import pmp_pkg::*;

    localparam int FILL_W = BUS_DW - PINS;
    localparam logic [FILL_W-1:0] FILL_HI = {FILL_W{1'b1}};
    localparam logic [BUS_DW-1:0] FILL_ALL = {BUS_DW{1'b1}};

    port_regs_t r_d, r_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[BUS_DW-1:PINS];

    always_comb begin
        r_d = r_q;
        if (bus_wr && !sw_stby) begin
            case (bus_addr)
                ADDR_DIR:  r_d.dir    = bus_wdata[PINS-1:0];
                ADDR_DAT:  r_d.dat    = bus_wdata[PINS-1:0];
                ADDR_PULL: r_d.pull   = bus_wdata[PINS-1:0];
                ADDR_OD:   r_d.odrain = bus_wdata[PINS-1:0];
                default:   ;
            endcase
        end
        if (!mrst_n) begin
            r_d.dat    = '0;
            r_d.pull   = '0;
            r_d.odrain = '0;
        end
        if (hw_stby) r_d = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_DIR:  bus_rdata = FILL_ALL;
                ADDR_DAT:  bus_rdata = {FILL_HI, r_q.dat};
                ADDR_PIN:  bus_rdata = {FILL_HI, pin_sync};
                ADDR_PULL: bus_rdata = {FILL_HI, r_q.pull};
                ADDR_OD:   bus_rdata = {FILL_HI, r_q.odrain};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign regs = r_q;

    // R7
    mrst_keeps_dir_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && !hw_stby) |=> (r_q.dir == $past(r_q.dir)));

    // R8
    hw_stby_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (r_q == '0));

    // R9
    sw_stby_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sw_stby && mrst_n && !hw_stby) |=> $stable(r_q));
endmodule

// File: rtl/pmp_pad_ctl.sv
module pmp_pad_ctl #(
    parameter int N = pmp_pkg::PINS
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [2:0]   mode,
    input  logic         hw_stby,
    input  logic         sw_stby,
    input  logic         stby_hold,
    input  logic [N-1:0] addr_en,
    input  logic [N-1:0] addr_out,
    input  logic [N-1:0] dir,
    input  logic [N-1:0] dat,
    input  logic [N-1:0] pull,
    input  logic [N-1:0] odrain,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe,
    output logic [N-1:0] pin_pu
);
    logic [N-1:0] held_d, held_q;
    logic [N-1:0] addr_sel;
    logic         expanded;

    assign expanded = pmp_pkg::is_expanded(mode);
    assign addr_sel = expanded ? addr_en : '0;

    always_comb begin
        held_d = sw_stby ? held_q : addr_out;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) held_q <= '0;
        else        held_q <= held_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            pin_out[i] = dat[i];
            pin_oe[i]  = 1'b0;
            pin_pu[i]  = 1'b0;
            if (hw_stby) begin
                pin_out[i] = 1'b0;
            end else if (addr_sel[i]) begin
                pin_out[i] = sw_stby ? held_q[i] : addr_out[i];
                pin_oe[i]  = sw_stby ? stby_hold : 1'b1;
            end else if (dir[i]) begin
                pin_oe[i]  = odrain[i] ? ~dat[i] : 1'b1;
            end else begin
                pin_pu[i]  = pull[i];
            end
        end
    end

    // R12
    pull_only_input_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((pin_pu & pin_oe) == '0));

    // R5
    addr_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        (expanded && !sw_stby && !hw_stby) |->
        (((pin_oe & addr_en) == addr_en) && ((pin_out & addr_en) == (addr_out & addr_en))));

    // R10
    stby_float_chk: assert property (@(posedge clk) disable iff (!por_n)
        (expanded && sw_stby && !stby_hold && !hw_stby) |-> ((pin_oe & addr_en) == '0));

    // R8
    hw_stby_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |-> ((pin_oe == '0) && (pin_pu == '0)));
endmodule

// File: rtl/pin_mux_port.sv
module pin_mux_port #(
    parameter logic [15:0] ADDR_DIR  = 16'hFE39,
    parameter logic [15:0] ADDR_DAT  = 16'hFF09,
    parameter logic [15:0] ADDR_PIN  = 16'hFFB9,
    parameter logic [15:0] ADDR_PULL = 16'hFE40,
    parameter logic [15:0] ADDR_OD   = 16'hFE47
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        mrst_n,
    input  logic        hw_stby,
    input  logic        sw_stby,
    input  logic        stby_hold,
    input  logic [2:0]  mode,
    input  logic [3:0]  addr_en,
    input  logic [3:0]  addr_out,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [3:0]  pin_in,
    output logic [3:0]  pin_out,
    output logic [3:0]  pin_oe,
    output logic [3:0]  pin_pu
);
    import pmp_pkg::*;

    pinvec_t    pin_sync;
    port_regs_t regs;

    pmp_sync #(.N(PINS)) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    pmp_regs #(
        .ADDR_DIR  (ADDR_DIR),
        .ADDR_DAT  (ADDR_DAT),
        .ADDR_PIN  (ADDR_PIN),
        .ADDR_PULL (ADDR_PULL),
        .ADDR_OD   (ADDR_OD)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .mrst_n    (mrst_n),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .regs      (regs)
    );

    pmp_pad_ctl #(.N(PINS)) u_pad (
        .clk       (clk),
        .por_n     (por_n),
        .mode      (mode),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .stby_hold (stby_hold),
        .addr_en   (addr_en),
        .addr_out  (addr_out),
        .dir       (regs.dir),
        .dat       (regs.dat),
        .pull      (regs.pull),
        .odrain    (regs.odrain),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu)
    );
endmodule

// File: tb/tb_pin_mux_port.sv
module tb_pin_mux_port;
    localparam logic [15:0] A_DIR  = 16'hFE39;
    localparam logic [15:0] A_DAT  = 16'hFF09;
    localparam logic [15:0] A_PIN  = 16'hFFB9;
    localparam logic [15:0] A_PULL = 16'hFE40;
    localparam logic [15:0] A_OD   = 16'hFE47;

    logic clk = 1'b0;
    logic por_n = 1'b0, mrst_n = 1'b1, hw_stby = 1'b0, sw_stby = 1'b0, stby_hold = 1'b0;
    logic [2:0]  mode = 3'd7;
    logic [3:0]  addr_en = '0, addr_out = '0, pin_in = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  pin_out, pin_oe, pin_pu;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rd_v;

    always #4 clk = ~clk;

    pin_mux_port dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .stby_hold(stby_hold), .mode(mode),
        .addr_en(addr_en), .addr_out(addr_out), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    typedef struct packed {
        logic [2:0] md;
        logic [3:0] en;
        logic [3:0] dir;
        logic [3:0] dat;
        logic [3:0] od;
        logic [3:0] pu_r;
        logic [3:0] x_oe;
        logic [3:0] x_out;
        logic [3:0] x_pu;
    } vec_t;

    // addr_out held at 4'b1001 for every row
    localparam vec_t VECS [7] = '{
        '{3'd7, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b1111},
        '{3'd7, 4'b1111, 4'b1100, 4'b1010, 4'b0000, 4'b0011, 4'b1100, 4'b1010, 4'b0011},
        '{3'd5, 4'b0011, 4'b1100, 4'b0110, 4'b0000, 4'b1111, 4'b1111, 4'b0101, 4'b0000},
        '{3'd4, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b1110, 4'b0001, 4'b0001, 4'b1110},
        '{3'd6, 4'b0000, 4'b1111, 4'b0101, 4'b1111, 4'b0000, 4'b1010, 4'b0101, 4'b0000},
        '{3'd7, 4'b0000, 4'b0011, 4'b0001, 4'b0010, 4'b1100, 4'b0011, 4'b0001, 4'b1100},
        '{3'd3, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0101, 4'b0000, 4'b0000, 4'b0101}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        // R1 reset state
        bus_read(A_DAT, rd_v);  chk("R1 data", rd_v, 8'hF0);
        bus_read(A_PULL, rd_v); chk("R1 pull", rd_v, 8'hF0);
        bus_read(A_OD, rd_v);   chk("R1 odrain", rd_v, 8'hF0);
        chk("R1 oe", {4'h0, pin_oe}, 8'h00);
        chk("R1 pu", {4'h0, pin_pu}, 8'h00);

        // R3 hidden direction, idle and unmapped reads
        bus_write(A_DIR, 8'h05);
        bus_read(A_DIR, rd_v); chk("R3 dir read", rd_v, 8'hFF);
        @(negedge clk); bus_addr = A_DAT; #1 chk("R3 no strobe", bus_rdata, 8'h00);
        bus_read(16'h1234, rd_v); chk("R3 unmapped", rd_v, 8'h00);

        // R2 reserved bits ignored
        bus_write(A_DAT, 8'hA5);
        bus_read(A_DAT, rd_v); chk("R2 data", rd_v, 8'hF5);

        // vector table: R4 R5 R6 R12 R13 R2
        addr_out = 4'b1001;
        foreach (VECS[k]) begin
            @(negedge clk);
            mode = VECS[k].md; addr_en = VECS[k].en;
            bus_write(A_DIR, {4'h0, VECS[k].dir});
            bus_write(A_DAT, {4'h0, VECS[k].dat});
            bus_write(A_OD,  {4'h0, VECS[k].od});
            bus_write(A_PULL, {4'h0, VECS[k].pu_r});
            #1;
            chk($sformatf("R4/R5/R6/R13 oe row %0d", k), {4'h0, pin_oe}, {4'h0, VECS[k].x_oe});
            chk($sformatf("R4/R5 out row %0d", k), {4'h0, pin_out}, {4'h0, VECS[k].x_out});
            chk($sformatf("R12 pu row %0d", k), {4'h0, pin_pu}, {4'h0, VECS[k].x_pu});
            bus_read(A_OD, rd_v);
            chk($sformatf("R2 od row %0d", k), rd_v, {4'hF, VECS[k].od});
        end

        // R7 manual reset keeps direction
        mode = 3'd7; addr_en = '0;
        bus_write(A_DIR, 8'h0F);
        bus_write(A_DAT, 8'h0F);
        bus_write(A_PULL, 8'h0F);
        @(negedge clk); mrst_n = 1'b0;
        @(negedge clk); mrst_n = 1'b1;
        bus_read(A_DAT, rd_v);  chk("R7 data cleared", rd_v, 8'hF0);
        bus_read(A_PULL, rd_v); chk("R7 pull cleared", rd_v, 8'hF0);
        chk("R7 dir kept oe", {4'h0, pin_oe}, 8'h0F);
        chk("R7 out", {4'h0, pin_out}, 8'h00);

        // R9 software standby freezes registers
        bus_write(A_DAT, 8'h03);
        @(negedge clk); sw_stby = 1'b1;
        bus_write(A_DAT, 8'h0C);
        bus_read(A_DAT, rd_v); chk("R9 write ignored", rd_v, 8'hF3);
        chk("R9 out kept", {4'h0, pin_out}, 8'h03);
        @(negedge clk); sw_stby = 1'b0;

        // R10 address hold and float in software standby
        mode = 3'd5; addr_en = 4'b1111; stby_hold = 1'b1; addr_out = 4'b1010;
        @(negedge clk); @(negedge clk);
        sw_stby = 1'b1; addr_out = 4'b0101;
        @(negedge clk); #1;
        chk("R10 held value", {4'h0, pin_out}, 8'h0A);
        chk("R10 held oe", {4'h0, pin_oe}, 8'h0F);
        stby_hold = 1'b0; #1;
        chk("R10 float", {4'h0, pin_oe}, 8'h00);
        @(negedge clk); sw_stby = 1'b0; #1;
        chk("R10 resume", {4'h0, pin_out}, 8'h05);

        // R8 hardware standby
        mode = 3'd7; addr_en = '0;
        bus_write(A_PULL, 8'h0F);
        @(negedge clk); hw_stby = 1'b1; #1;
        chk("R8 oe forced", {4'h0, pin_oe}, 8'h00);
        @(negedge clk); hw_stby = 1'b0; #1;
        chk("R8 dir cleared", {4'h0, pin_oe}, 8'h00);
        chk("R8 pu after", {4'h0, pin_pu}, 8'h00);
        bus_read(A_PULL, rd_v); chk("R8 pull cleared", rd_v, 8'hF0);

        // R11 two-edge synchronizer on pin reads
        pin_in = 4'b0000;
        repeat (3) @(negedge clk);
        pin_in = 4'b1011;
        @(negedge clk);
        bus_addr = A_PIN; bus_rd = 1'b1; #1;
        chk("R11 after one edge", bus_rdata, 8'hF0);
        @(negedge clk); #1;
        chk("R11 after two edges", bus_rdata, 8'hFB);
        bus_rd = 1'b0;

        finish_up();
    end
endmodule